// File: doc/BRIEF.md
# Byte Lane Steering and Alignment Unit

This block sits between the load/store stage of a pipeline and a data memory that is one 32-bit word wide. On a store it moves a byte, halfword or word onto the byte lanes it occupies in the addressed word and produces the matching byte-enable mask. On a load it takes the lanes of the returned word that belong to the access and sign-extends or zero-extends them to 32 bits.

Every request is checked for natural alignment before it reaches memory. An access whose address is not a multiple of its size is not performed. The block raises a one-cycle fault pulse instead, so that a software handler can emulate the access. A live mode input selects whether the lowest byte address maps to the most significant lane (big-endian) or to the least significant lane (little-endian). The mode is sampled together with each request.

Top module: `lsu_lane_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, mem_en, mem_we, mem_be, mem_wdata, align_fault, ld_valid and ld_data are all zero.
- R2: The size code is 0 for byte, 1 for halfword and 2 for word. A byte may use any offset. A halfword needs address bit 0 clear. A word needs address bits 1:0 equal to 00. A request that breaks this rule sets align_fault in the next cycle, and in that cycle mem_en is 0 and mem_be is 0000.
- R3: Size code 3 is illegal at every offset and is reported through align_fault exactly like a misaligned access.
- R4: Lane i is mem_wdata bits 8i+7:8i and mem_be bit i. With big_endian=0, a byte store at offset k drives lane k only. A halfword store at offset 0 or 2 drives lanes k and k+1, with data bits 7:0 in lane k. Lanes that are not enabled carry zero.
- R5: With big_endian=1, a byte store at offset k drives lane 3-k only. A halfword store at offset k drives lanes 3-k and 2-k, with data bits 15:8 in lane 3-k.
- R6: A word store enables all four lanes and passes the data through unchanged in both modes. As a result, the value 515 written big-endian reads back as bytes 00 00 02 03 at offsets 0..3, and written little-endian as 03 02 00 00.
- R7: A load uses the same lane mapping as a store of the same size, offset and mode. An unsigned byte or halfword load fills the upper bits with zero.
- R8: A signed byte or halfword load copies the top bit of the selected data into all upper bits.
- R9: mem_en, mem_we, mem_be, mem_wdata and mem_word_addr (the address with its two low bits dropped) appear in the cycle after the request. For a read, ld_valid and ld_data appear in the cycle after that, taken from mem_rdata as presented with the read.
- R10: A faulted load never raises ld_valid.
- R11: A cycle with req_valid low produces neither mem_en nor align_fault in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_signed | input | 1 | Sign-extend a load result |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| big_endian | input | 1 | 1 = lowest address is most significant lane |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_be | output | 4 | Byte-lane enables |
| mem_word_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Word returned for the read issued last cycle |
| align_fault | output | 1 | Misaligned or illegal access pulse |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Extended load result |

## Verification
The bench builds the unit with ADDR_W set to 8 and attaches a 64-word memory model. With this setting every offset of every size, in both modes, can be written and read back across a handful of words. The fault cases for both sizes that have alignment limits, and for the illegal size code, fall in the same small address range. Lane placement is checked directly on the memory-side pins. Extraction and extension are checked through a round trip of a known word whose lanes differ in their top bits.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  function automatic logic [2:0] size_bytes(acc_size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // natural alignment: offset is a multiple of the access size
  function automatic logic access_ok(acc_size_e s, logic [1:0] off);
    case (s)
      SZ_BYTE: return 1'b1;
      SZ_HALF: return ~off[0];
      SZ_WORD: return (off == 2'b00);
      default: return 1'b0;
    endcase
  endfunction

  // lowest lane occupied by the access
  function automatic logic [1:0] lane_base(acc_size_e s, logic [1:0] off, logic big);
    logic [2:0] t;
    if (big) t = 3'd4 - size_bytes(s) - {1'b0, off};
    else     t = {1'b0, off};
    return t[1:0];
  endfunction

  function automatic logic [LANES-1:0] lane_mask(acc_size_e s, logic [1:0] base);
    logic [LANES-1:0] m;
    case (s)
      SZ_BYTE: m = 4'b0001;
      SZ_HALF: m = 4'b0011;
      default: m = 4'b1111;
    endcase
    return m << base;
  endfunction

  function automatic logic [DATA_W-1:0] place_lanes(logic [DATA_W-1:0] wd, acc_size_e s,
                                                     logic [1:0] base);
    logic [DATA_W-1:0] v;
    case (s)
      SZ_BYTE: v = {24'd0, wd[7:0]};
      SZ_HALF: v = {16'd0, wd[15:0]};
      default: v = wd;
    endcase
    return v << {base, 3'b000};
  endfunction

  function automatic logic [DATA_W-1:0] pick_lanes(logic [DATA_W-1:0] rd, acc_size_e s,
                                                    logic [1:0] base, logic sgn);
    logic [DATA_W-1:0] sh;
    sh = rd >> {base, 3'b000};
    case (s)
      SZ_BYTE: return {{24{sgn & sh[7]}}, sh[7:0]};
      SZ_HALF: return {{16{sgn & sh[15]}}, sh[15:0]};
      default: return sh;
    endcase
  endfunction
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_lane_pkg::*;
(
  input  acc_size_e  size,
  input  logic [1:0] off,
  output logic       fault
);
  assign fault = ~access_ok(size, off);
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_lane_pkg::*;
(
  input  acc_size_e          size,
  input  logic [1:0]         off,
  input  logic               big,
  input  logic [DATA_W-1:0]  wdata,
  output logic [1:0]         base,
  output logic [LANES-1:0]   be,
  output logic [DATA_W-1:0]  lanes
);
  assign base  = lane_base(size, off, big);
  assign be    = lane_mask(size, base);
  assign lanes = place_lanes(wdata, size, base);
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_lane_pkg::*;
(
  input  logic [DATA_W-1:0] rdata,
  input  acc_size_e         size,
  input  logic [1:0]        base,
  input  logic              sgn,
  output logic [DATA_W-1:0] value
);
  assign value = pick_lanes(rdata, size, base, sgn);
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              big_endian,
  output logic              mem_en,
  output logic              mem_we,
  output logic [3:0]        mem_be,
  output logic [ADDR_W-3:0] mem_word_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              align_fault,
  output logic              ld_valid,
  output logic [31:0]       ld_data
);
  localparam int WADDR_W = ADDR_W - 2;

  acc_size_e          req_sz;
  logic [1:0]         req_off;
  logic               fault_now;
  logic [1:0]         base_now;
  logic [LANES-1:0]   be_now;
  logic [DATA_W-1:0]  lanes_now;

  assign req_sz  = acc_size_e'(req_size);
  assign req_off = req_addr[1:0];

  lsu_align_check u_chk_align (
    .size  (req_sz),
    .off   (req_off),
    .fault (fault_now)
  );

  lsu_store_steer u_steer (
    .size  (req_sz),
    .off   (req_off),
    .big   (big_endian),
    .wdata (req_wdata),
    .base  (base_now),
    .be    (be_now),
    .lanes (lanes_now)
  );

  // named events for the checker
  logic issue_ok, issue_bad, read_issued;
  assign issue_ok  = req_valid & ~fault_now;
  assign issue_bad = req_valid & fault_now;

  // request stage
  logic               en_q, we_q, fault_q;
  logic [LANES-1:0]   be_q;
  logic [DATA_W-1:0]  wd_q;
  logic [WADDR_W-1:0] wa_q;
  acc_size_e          ctx_size_q;
  logic [1:0]         ctx_base_q;
  logic               ctx_sgn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      we_q       <= 1'b0;
      fault_q    <= 1'b0;
      be_q       <= '0;
      wd_q       <= '0;
      wa_q       <= '0;
      ctx_size_q <= SZ_BYTE;
      ctx_base_q <= 2'b00;
      ctx_sgn_q  <= 1'b0;
    end else begin
      en_q    <= issue_ok;
      we_q    <= issue_ok & req_write;
      fault_q <= issue_bad;
      be_q    <= issue_ok ? be_now : '0;
      wd_q    <= (issue_ok & req_write) ? lanes_now : '0;
      if (req_valid) begin
        wa_q       <= req_addr[ADDR_W-1:2];
        ctx_size_q <= req_sz;
        ctx_base_q <= base_now;
        ctx_sgn_q  <= req_signed;
      end
    end
  end

  assign read_issued = en_q & ~we_q;

  logic [DATA_W-1:0] extracted;

  lsu_load_extract u_extract (
    .rdata (mem_rdata),
    .size  (ctx_size_q),
    .base  (ctx_base_q),
    .sgn   (ctx_sgn_q),
    .value (extracted)
  );

  // load return stage
  logic              ldv_q;
  logic [DATA_W-1:0] ld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldv_q <= 1'b0;
      ld_q  <= '0;
    end else begin
      ldv_q <= read_issued;
      if (read_issued) ld_q <= extracted;
    end
  end

  assign mem_en        = en_q;
  assign mem_we        = we_q;
  assign mem_be        = be_q;
  assign mem_word_addr = wa_q;
  assign mem_wdata     = wd_q;
  assign align_fault   = fault_q;
  assign ld_valid      = ldv_q;
  assign ld_data       = ld_q;
endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       mem_en,
  input logic       mem_we,
  input logic [3:0] mem_be,
  input logic       align_fault,
  input logic       ld_valid
);
  p_fault_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> (!mem_en && mem_be == 4'b0000));

  p_fault_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> $past(req_valid));

  p_issue_from_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> $past(req_valid));

  p_lanes_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                $countones(mem_be) == 4));

  p_ld_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_en && !mem_we));

  p_fault_no_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |=> !ld_valid);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!mem_en && !align_fault));
endmodule

bind lsu_lane_unit lsu_lane_unit_chk u_lane_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .mem_be      (mem_be),
  .align_fault (align_fault),
  .ld_valid    (ld_valid)
);

// File: tb/sim_lsu_lane_unit.sv
`timescale 1ns/1ps
module sim_lsu_lane_unit;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 0, req_write = 0, req_signed = 0, big_endian = 0;
  logic [1:0]    req_size = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0]   req_wdata = 0;
  logic          mem_en, mem_we, align_fault, ld_valid;
  logic [3:0]    mem_be;
  logic [AW-3:0] mem_word_addr;
  logic [31:0]   mem_wdata, mem_rdata, ld_data;

  lsu_lane_unit #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .req_wdata(req_wdata), .big_endian(big_endian), .mem_en(mem_en),
    .mem_we(mem_we), .mem_be(mem_be), .mem_word_addr(mem_word_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .align_fault(align_fault),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  logic [31:0] mem [64];
  assign mem_rdata = mem[mem_word_addr];
  always @(posedge clk) begin
    if (mem_en && mem_we)
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) mem[mem_word_addr][8*i +: 8] <= mem_wdata[8*i +: 8];
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  logic        s_en, s_we, s_fault, s_ldv, s_en2, s_fault2;
  logic [3:0]  s_be;
  logic [31:0] s_wd, s_ld;
  logic [AW-3:0] s_wa;

  task automatic access(input logic we, input logic [1:0] sz, input logic sg,
                        input logic [AW-1:0] ad, input logic [31:0] wd, input logic bg);
    @(negedge clk);
    req_valid = 1; req_write = we; req_size = sz; req_signed = sg;
    req_addr = ad; req_wdata = wd; big_endian = bg;
    @(posedge clk); #1;
    s_en = mem_en; s_we = mem_we; s_be = mem_be; s_wd = mem_wdata;
    s_fault = align_fault; s_wa = mem_word_addr;
    @(negedge clk);
    req_valid = 0; big_endian = ~bg;
    @(posedge clk); #1;
    s_ldv = ld_valid; s_ld = ld_data; s_en2 = mem_en; s_fault2 = align_fault;
  endtask

  // {big, size, off, fault, be, wdata} with store data A1B2C3D4
  localparam logic [41:0] TBL [12] = '{
    {1'b0, 2'd0, 2'd0, 1'b0, 4'b0001, 32'h000000D4},
    {1'b0, 2'd0, 2'd3, 1'b0, 4'b1000, 32'hD4000000},
    {1'b1, 2'd0, 2'd0, 1'b0, 4'b1000, 32'hD4000000},
    {1'b1, 2'd0, 2'd2, 1'b0, 4'b0010, 32'h0000D400},
    {1'b0, 2'd1, 2'd2, 1'b0, 4'b1100, 32'hC3D40000},
    {1'b1, 2'd1, 2'd0, 1'b0, 4'b1100, 32'hC3D40000},
    {1'b1, 2'd1, 2'd2, 1'b0, 4'b0011, 32'h0000C3D4},
    {1'b0, 2'd2, 2'd0, 1'b0, 4'b1111, 32'hA1B2C3D4},
    {1'b1, 2'd2, 2'd0, 1'b0, 4'b1111, 32'hA1B2C3D4},
    {1'b0, 2'd1, 2'd1, 1'b1, 4'b0000, 32'h00000000},
    {1'b1, 2'd2, 2'd2, 1'b1, 4'b0000, 32'h00000000},
    {1'b0, 2'd3, 2'd0, 1'b1, 4'b0000, 32'h00000000}
  };

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset mem_en", {31'd0, mem_en}, 0);
    chk("R1 reset fault", {31'd0, align_fault}, 0);
    chk("R1 reset ld", {31'd0, ld_valid} | ld_data | mem_wdata | {28'd0, mem_be}, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 after release", {30'd0, mem_en, ld_valid}, 0);

    // store lane table (R2 R3 R4 R5 R6)
    for (int i = 0; i < 12; i++) begin
      logic [41:0] e;
      e = TBL[i];
      access(1'b1, e[40:39], 1'b0, AW'(16 + e[38:37]), 32'hA1B2C3D4, e[41]);
      chk($sformatf("R2 R3 fault row %0d", i), {31'd0, s_fault}, {31'd0, e[36]});
      chk($sformatf("R4 R5 R6 be row %0d", i), {28'd0, s_be}, {28'd0, e[35:32]});
      chk($sformatf("R4 R5 R6 data row %0d", i), s_wd, e[31:0]);
      chk($sformatf("R2 en row %0d", i), {31'd0, s_en}, {31'd0, ~e[36]});
      chk($sformatf("R11 idle row %0d", i), {30'd0, s_en2, s_fault2}, 0);
    end

    // load round trip (R7 R8 R9)
    access(1'b1, 2'd2, 1'b0, 8'd4, 32'h80F17F02, 1'b0);
    chk("R9 word addr", {26'd0, s_wa}, 32'd1);
    chk("R9 store no ld_valid", {31'd0, s_ldv}, 0);
    access(1'b0, 2'd0, 1'b0, 8'd4, 0, 1'b0);
    chk("R9 read strobe", {30'd0, s_en, s_we}, 32'd2);
    chk("R9 ld_valid", {31'd0, s_ldv}, 1);
    chk("R7 LE byte0 unsigned", s_ld, 32'h00000002);
    access(1'b0, 2'd0, 1'b1, 8'd7, 0, 1'b0);
    chk("R8 LE byte3 signed", s_ld, 32'hFFFFFF80);
    access(1'b0, 2'd0, 1'b0, 8'd4, 0, 1'b1);
    chk("R7 BE byte0 unsigned", s_ld, 32'h00000080);
    access(1'b0, 2'd0, 1'b1, 8'd5, 0, 1'b1);
    chk("R8 BE byte1 signed", s_ld, 32'hFFFFFFF1);
    access(1'b0, 2'd1, 1'b1, 8'd6, 0, 1'b0);
    chk("R8 LE half2 signed", s_ld, 32'hFFFF80F1);
    access(1'b0, 2'd1, 1'b1, 8'd4, 0, 1'b0);
    chk("R8 LE half0 signed positive", s_ld, 32'h00007F02);
    access(1'b0, 2'd1, 1'b0, 8'd6, 0, 1'b1);
    chk("R7 BE half2 unsigned", s_ld, 32'h00007F02);
    access(1'b0, 2'd1, 1'b1, 8'd4, 0, 1'b1);
    chk("R8 BE half0 signed", s_ld, 32'hFFFF80F1);
    access(1'b0, 2'd2, 1'b1, 8'd4, 0, 1'b1);
    chk("R7 word load", s_ld, 32'h80F17F02);

    // 515 ordering (R6)
    access(1'b1, 2'd2, 1'b0, 8'd8, 32'd515, 1'b1);
    access(1'b0, 2'd0, 1'b0, 8'd8, 0, 1'b1);
    chk("R6 BE 515 offset0", s_ld, 32'h00);
    access(1'b0, 2'd0, 1'b0, 8'd11, 0, 1'b1);
    chk("R6 BE 515 offset3", s_ld, 32'h03);
    access(1'b0, 2'd0, 1'b0, 8'd8, 0, 1'b0);
    chk("R6 LE 515 offset0", s_ld, 32'h03);
    access(1'b0, 2'd0, 1'b0, 8'd9, 0, 1'b0);
    chk("R6 LE 515 offset1", s_ld, 32'h02);

    // faulted load (R10)
    access(1'b0, 2'd1, 1'b1, 8'd5, 0, 1'b0);
    chk("R10 fault flagged", {31'd0, s_fault}, 1);
    chk("R10 no ld_valid", {31'd0, s_ldv}, 0);
    access(1'b0, 2'd2, 1'b0, 8'd7, 0, 1'b1);
    chk("R2 word offset3 fault", {31'd0, s_fault}, 1);
    chk("R10 word fault no ld_valid", {31'd0, s_ldv}, 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R9 got=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule